// File: doc/BRIEF.md
# USB Device-to-Host Transmit Packetizer

This block sits between a byte-wide parallel writer and the device-to-host side of a USB bridge. The writer pushes bytes into a 256-byte transmit buffer. It watches an active-low space flag that is low while at least one slot is free. A framing engine empties the buffer in response to host poll strobes. Each response is either a packet or a single-cycle NAK. A packet always starts with two status bytes, which report the overflow flag and the fill count, and carries at most 62 payload bytes. The framing engine therefore never emits more than 64 bytes per packet.

A full 62-byte payload is sent as soon as enough data is buffered. A smaller remainder is held back until a programmable latency timer, counted in clock cycles, has run out. Polls can land at any point in a writer's burst. The writer must therefore rely on the space flag and the sticky overflow flag, and cannot rely on its own byte counts. Writes that reach a full buffer are discarded and latch the overflow flag.

Top module: `usb_tx_packetizer`

## Requirements
- R1: After reset the buffer is empty (`fill_count` 0), `room_n` is 0, `ovf` is 0, and neither `out_valid` nor `nak` is asserted.
- R2: A write with `wr_en` high while fewer than 256 bytes are held appends `wr_data` and raises `fill_count` by one. `room_n` is 1 exactly when 256 bytes are held.
- R3: A write while 256 bytes are held is discarded and sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed. If a discarded write and `ovf_clr` occur in the same cycle, `ovf` stays set.
- R4: A poll (`host_req` high in a cycle with no packet in flight) with at least 62 bytes held starts a packet on the next cycle. The packet is 2 status bytes followed by the 62 oldest buffered bytes in write order, one byte per cycle with `out_valid` high.
- R5: Status byte 0 has bit 0 equal to `ovf` at the poll and all other bits 0. Status byte 1 is the fill count at the poll, saturated to 255.
- R6: A poll with 1 to 61 bytes held and the latency timer expired sends a packet whose payload is every held byte.
- R7: A poll that sends nothing (buffer empty, or fewer than 62 bytes with the timer not expired) pulses `nak` for one cycle on the next cycle, with `out_valid` low.
- R8: The timer is expired once `lat_period` clock edges have passed since its last restart. It restarts when a packet is accepted and when a write lands in an empty buffer.
- R9: `host_req` is ignored while a packet is being sent: it produces neither a NAK nor a second packet.
- R10: Writes are accepted while a packet is being sent, and the bytes popped by the packet are subtracted from `fill_count` in the same cycles.
- R11: `out_first` is high on status byte 0 only, and `out_last` is high on the final payload byte only. `out_valid` drops on the cycle after `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the parallel side |
| wr_data | input | 8 | Byte to store |
| room_n | output | 1 | Low while at least one slot is free |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| lat_period | input | 16 | Latency timer period in clock cycles |
| host_req | input | 1 | Host poll strobe |
| out_valid | output | 1 | Packet byte present on `out_data` |
| out_data | output | 8 | Packet byte stream |
| out_first | output | 1 | Marks status byte 0 |
| out_last | output | 1 | Marks the final payload byte |
| nak | output | 1 | One-cycle empty response to a poll |
| fill_count | output | 9 | Bytes currently buffered |

## Verification
The assertions assume that `lat_period` holds steady across a timer restart and the cycle after it. They also assume `host_req` is a clean synchronous level sampled on the clock edge. The stimulus sets `lat_period` once, before reset is released, and never changes it. Every input is driven on the falling edge, so each rising edge sees stable values. Polls are issued on empty, partly filled, exactly full and saturated buffers, as well as during packets.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_STAT0 = 2'd1,
    FR_STAT1 = 2'd2,
    FR_PAY   = 2'd3
  } fr_state_e;

  // Fill count as reported in the second status byte: clipped to 8 bits.
  function automatic logic [7:0] sat_fill(input int unsigned lvl);
    if (lvl > 255) return 8'hFF;
    return lvl[7:0];
  endfunction

  // Payload length granted to a poll; zero means NAK.
  function automatic int unsigned pick_len(input int unsigned lvl,
                                           input int unsigned max_pl,
                                           input logic        expired);
    if (lvl >= max_pl) return max_pl;
    if (expired && lvl != 0) return lvl;
    return 0;
  endfunction

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign rdata = mem[rd_ptr];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0); // R4
  AST_PUSH_NOTFULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> level < LW'(DEPTH)); // R3

endmodule

// File: rtl/txb_lat_timer.sv
module txb_lat_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] period,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt < period)   cnt <= cnt + TW'(1);
  end

  assign expired = (cnt >= period);

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart && period != '0 ##1 $stable(period) |-> !expired); // R8

endmodule

// File: rtl/txb_framer.sv
module txb_framer
  import usbtx_pkg::*;
#(
  parameter int PAYLOAD = 62,
  parameter int LW      = 9,
  localparam int PW     = $clog2(PAYLOAD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic [LW-1:0] level,
  input  logic          ovf,
  input  logic          expired,
  input  logic [7:0]    rdata,
  output logic          pop,
  output logic          accept,
  output logic          nak,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last
);

  fr_state_e     state;
  logic [PW-1:0] remain;
  logic [PW-1:0] send_len;
  logic [7:0]    stat0, stat1;
  logic          poll;

  assign poll     = (state == FR_IDLE) && host_req;
  assign send_len = PW'(pick_len(32'(level), PAYLOAD, expired));
  assign accept   = poll && (send_len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FR_IDLE;
      remain <= '0;
      stat0  <= '0;
      stat1  <= '0;
      nak    <= 1'b0;
    end else begin
      nak <= poll && !accept;
      case (state)
        FR_IDLE: if (accept) begin
          stat0  <= {7'b0, ovf};
          stat1  <= sat_fill(32'(level));
          remain <= send_len;
          state  <= FR_STAT0;
        end
        FR_STAT0: state <= FR_STAT1;
        FR_STAT1: state <= FR_PAY;
        FR_PAY: begin
          remain <= remain - PW'(1);
          if (remain == PW'(1)) state <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assign pop       = (state == FR_PAY);
  assign out_valid = (state != FR_IDLE);
  assign out_first = (state == FR_STAT0);
  assign out_last  = (state == FR_PAY) && (remain == PW'(1));

  always_comb begin
    case (state)
      FR_STAT0: out_data = stat0;
      FR_STAT1: out_data = stat1;
      FR_PAY:   out_data = rdata;
      default:  out_data = 8'h00;
    endcase
  end

  AST_BUSY_NO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && host_req |=> !nak); // R9
  AST_NAK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> !out_valid); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid); // R11
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first); // R11
  AST_SHORT_NEEDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    accept && level < LW'(PAYLOAD) |-> expired); // R6

endmodule

// File: rtl/usb_tx_packetizer.sv
module usb_tx_packetizer #(
  parameter int DEPTH   = 256,
  parameter int PAYLOAD = 62,
  parameter int TW      = 16,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          room_n,
  input  logic          ovf_clr,
  output logic          ovf,
  input  logic [TW-1:0] lat_period,
  input  logic          host_req,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_first,
  output logic          out_last,
  output logic          nak,
  output logic [LW-1:0] fill_count
);

  // Named internal events
  logic       ev_push, ev_drop, ev_pop, ev_accept, ev_restart, ev_expired;
  logic [7:0] head_byte;

  assign room_n     = (fill_count == LW'(DEPTH));
  assign ev_push    = wr_en && !room_n;
  assign ev_drop    = wr_en && room_n;
  assign ev_restart = ev_accept || (ev_push && fill_count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (ev_drop) ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  txb_fifo #(.DEPTH(DEPTH), .W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .wdata(wr_data),
    .pop(ev_pop), .rdata(head_byte), .level(fill_count)
  );

  txb_lat_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(ev_restart),
    .period(lat_period), .expired(ev_expired)
  );

  txb_framer #(.PAYLOAD(PAYLOAD), .LW(LW)) u_framer (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .level(fill_count),
    .ovf(ovf), .expired(ev_expired), .rdata(head_byte), .pop(ev_pop),
    .accept(ev_accept), .nak(nak), .out_valid(out_valid),
    .out_data(out_data), .out_first(out_first), .out_last(out_last)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && room_n && !ev_pop |=> room_n); // R3
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ovf); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R3
  AST_WRITE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push && !ev_pop |=> fill_count == $past(fill_count) + LW'(1)); // R2

endmodule

// File: tb/test_usb_tx_packetizer.sv
module test_usb_tx_packetizer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, ovf_clr = 1'b0, host_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [15:0] lat_period = 16'd20;
  logic       room_n, ovf, out_valid, out_first, out_last, nak;
  logic [7:0] out_data;
  logic [8:0] fill_count;

  always #4 clk = ~clk;

  usb_tx_packetizer i_usb_tx_packetizer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .room_n(room_n), .ovf_clr(ovf_clr), .ovf(ovf), .lat_period(lat_period),
    .host_req(host_req), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .nak(nak),
    .fill_count(fill_count)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  byte unsigned q[$];
  int  phase, rem, tcnt, lvl, plen;
  bit  ovf_m, nak_m, exp_m, push_m, drop_m, acc_m;
  byte unsigned s0, s1;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); phase = 0; rem = 0; tcnt = 0; ovf_m = 0; nak_m = 0;
      s0 = 0; s1 = 0;
    end else begin
      lvl    = q.size();
      exp_m  = tcnt >= int'(lat_period);
      push_m = wr_en && lvl < 256;
      drop_m = wr_en && lvl == 256;
      plen   = (lvl >= 62) ? 62 : ((exp_m && lvl > 0) ? lvl : 0);
      acc_m  = (phase == 0) && host_req && plen > 0;
      nak_m  = (phase == 0) && host_req && plen == 0;
      if (phase == 3) begin
        void'(q.pop_front()); rem--;
        if (rem == 0) phase = 0;
      end else if (phase == 2) phase = 3;
      else if (phase == 1) phase = 2;
      else if (acc_m) begin
        s0 = ovf_m; s1 = (lvl > 255) ? 255 : lvl; rem = plen; phase = 1;
      end
      if (push_m) q.push_back(wr_data);
      if (drop_m) ovf_m = 1; else if (ovf_clr) ovf_m = 0;
      if (acc_m || (push_m && lvl == 0)) tcnt = 0;
      else if (tcnt < int'(lat_period)) tcnt++;
    end
  end

  // ---------------- per-cycle comparison and packet capture ----------------
  byte unsigned pkt[$];
  int last_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "out_valid R4", int'(out_valid), int'(phase != 0));
      check(tag, "nak R7", int'(nak), int'(nak_m));
      check(tag, "ovf R3", int'(ovf), int'(ovf_m));
      check(tag, "fill_count R2", int'(fill_count), q.size());
      check(tag, "room_n R2", int'(room_n), int'(q.size() == 256));
      if (phase != 0) begin
        check(tag, "out_first R11", int'(out_first), int'(phase == 1));
        check(tag, "out_last R11", int'(out_last), int'(phase == 3 && rem == 1));
        check(tag, "out_data R5", int'(out_data),
              phase == 1 ? int'(s0) : phase == 2 ? int'(s1) : int'(q[0]));
      end
      if (out_valid) begin
        if (out_first) pkt.delete();
        pkt.push_back(out_data);
        if (out_last) last_len = pkt.size();
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  byte unsigned seed = 8'h10;

  task automatic put(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = seed; seed++;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic poll(output bit got_nak);
    host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
    got_nak = nak;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100 && (phase != 0); i++) @(negedge clk);
  endtask

  bit g;

  initial begin
    idle(3);
    tag = "R1";
    check("R1", "fill_count", int'(fill_count), 0);
    check("R1", "room_n", int'(room_n), 0);
    check("R1", "ovf", int'(ovf), 0);
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "nak", int'(nak), 0);
    rst_n = 1'b1;
    idle(2);

    tag = "R7"; poll(g); check("R7", "nak on empty", int'(g), 1);
    idle(2);

    tag = "R7"; put(10); poll(g); check("R7", "nak before timer", int'(g), 1);
    idle(25);
    tag = "R6"; poll(g); check("R6", "no nak when expired", int'(g), 0);
    wait_done(); idle(1);
    check("R6", "short packet length", last_len, 12);

    tag = "R4"; put(64); poll(g); wait_done(); idle(1);
    check("R4", "full packet length", last_len, 64);
    check("R5", "status fill byte", int'(pkt[1]), 64);
    tag = "R6"; idle(25); poll(g); wait_done(); idle(1);
    check("R6", "remainder packet length", last_len, 4);

    tag = "R8"; put(1); idle(17); poll(g);
    check("R8", "nak before period", int'(g), 1);
    idle(5); poll(g); check("R8", "sent after period", int'(g), 0);
    wait_done(); idle(1);

    tag = "R9"; put(70); poll(g);
    for (int i = 0; i < 10; i++) begin host_req = 1'b1; @(negedge clk); end
    host_req = 1'b0;
    tag = "R10"; put(5); wait_done(); idle(1);
    check("R9", "one packet only", last_len, 64);
    check("R10", "level after overlap", int'(fill_count), 13);
    idle(25); poll(g); wait_done(); idle(1);

    tag = "R2"; put(256); check("R2", "room_n at full", int'(room_n), 1);
    tag = "R3"; put(2); check("R3", "ovf set", int'(ovf), 1);
    idle(3); check("R3", "ovf sticky", int'(ovf), 1);
    check("R3", "level kept", int'(fill_count), 256);
    tag = "R5"; poll(g); wait_done(); idle(1);
    check("R5", "status ovf bit", int'(pkt[0]), 1);
    check("R5", "status saturated fill", int'(pkt[1]), 255);
    tag = "R3"; put(62);
    wr_en = 1'b1; ovf_clr = 1'b1; @(negedge clk); wr_en = 1'b0; ovf_clr = 1'b0;
    check("R3", "set beats clear", int'(ovf), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R3", "cleared", int'(ovf), 0);
    tag = "R4";
    for (int k = 0; k < 6; k++) begin poll(g); wait_done(); idle(2); end
    tag = "R11"; idle(25); poll(g); wait_done(); idle(2);
    check("R11", "drained", int'(fill_count), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule